// File: doc/BRIEF.md
# Serial Button Readout Port

This block presents eight button inputs to a processor through a single byte-wide I/O location. A write to the location sets or clears a strobe flag taken from data bit 0. While the strobe is set the block keeps copying the live button inputs into an internal holding register. Every read returns the button at position 0. Clearing the strobe freezes the holding register at the edge of that write. Reads then deliver the held buttons one per access, in order from 0 to 7.

Each read returns the selected button in data bit 0, with the upper bits at zero. Each read then steps a 3-bit index. The button is selected by the index ANDed with a mask. Setting the strobe forces the mask to zero and clears the index. Clearing the strobe opens the mask to all ones. Reads made while the strobe is set still step the index. The first read after release therefore begins wherever the index has reached, and the walk does not always restart at 0.

Top module: `btn_serial_port`

## Requirements
- R1: After reset the index is 0, the mask is all ones, the strobe is clear and the held buttons are all zero. A read before any strobe therefore returns 0x00, whatever the button inputs are.
- R2: A write with data bit 0 = 1 sets the strobe, sets the mask to 0 and clears the index. While the strobe is set, every read returns the held button 0. That value follows the live input, as it was sampled at the previous clock edge.
- R3: A write with data bit 0 = 0 clears the strobe and captures the button inputs at the clock edge of that write. Later changes on the button inputs do not alter what is read out.
- R4: With the strobe clear, successive reads return held buttons index 0, 1, 2 … 7 in that order. Button k is input bit k.
- R5: The index is 3 bits wide and wraps. The ninth read after a capture with index 0 returns button 0 again.
- R6: Read data carries the selected button in bit 0 and zero in bits 7:1. In any cycle without a read hit, read data is 0x00.
- R7: Only data bit 0 of a write is used. A write of 0xFE behaves as a strobe clear, and a write of 0xFF behaves as a strobe set.
- R8: Read or write strobes without the address hit have no effect: no index step, no strobe change, and read data 0x00.
- R9: Reads made while the strobe is set still advance the index. After release, the first read returns held button (number of strobed reads mod 8).
- R10: When a read and a write hit in the same cycle, the read returns data from the state before the write. A strobe-setting write then clears the index, taking priority over the read step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_hit | input | 1 | Address decode hit for this I/O location |
| rd_stb | input | 1 | Read strobe, one access per cycle |
| wr_stb | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 8 | Write data; bit 0 is the strobe flag |
| rd_data | output | 8 | Read data; button in bit 0 |
| buttons | input | 8 | Parallel button inputs, bit k is button k |

## Verification
The bench targets the index behaviour around the strobe, which is where a shift-register design diverges. One case reads during the strobe, and a design that reset the index on release would return button 0 instead of button 3. Another case is the ninth read: a design with a saturating index, or one that returns a fixed 1 after eight reads, would fail it. Two further cases cover a combined read-and-write cycle and button changes after the capture. Without address hit gating, or with capture at the wrong edge, these cases show a stepped index or bits that changed after release.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;
   // Bit of the write data that carries the strobe flag
   localparam int unsigned STROBE_BIT = 0;
   // Bit of the read data that carries the selected button
   localparam int unsigned BUTTON_BIT = 0;

   function automatic logic [7:0] fmt_byte(input logic b);
      fmt_byte = 8'h00;
      fmt_byte[BUTTON_BIT] = b;
   endfunction
endpackage

// File: rtl/btn_latch.sv
module btn_latch #(
   parameter int unsigned NUM_BTN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit,
   input  logic               strobe_set,
   input  logic [NUM_BTN-1:0] btn_in,
   output logic               strobe_q,
   output logic [NUM_BTN-1:0] held_q
);
   generate
      if (NUM_BTN < 1) begin : g_bad_n
         $error("btn_latch: NUM_BTN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
      end else if (wr_hit) begin
         strobe_q <= strobe_set;
      end
   end

   // Transparent while strobed; freezes at the edge that clears the strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (strobe_q) begin
         held_q <= btn_in;
      end
   end

   AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_q |=> $stable(held_q)); // R3
endmodule

// File: rtl/btn_index.sv
module btn_index #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_hit,
   input  logic             wr_hit,
   input  logic             strobe_set,
   output logic [IDX_W-1:0] idx_q,
   output logic [IDX_W-1:0] mask_q,
   output logic [IDX_W-1:0] sel_idx
);
   localparam logic [IDX_W-1:0] MASK_OPEN = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

   generate
      if (IDX_W < 1) begin : g_bad_w
         $error("btn_index: IDX_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= MASK_OPEN;
      end else if (wr_hit) begin
         mask_q <= strobe_set ? '0 : MASK_OPEN;
      end
   end

   // Clear on strobe set has priority over a read step in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (wr_hit && strobe_set) begin
         idx_q <= '0;
      end else if (rd_hit) begin
         idx_q <= idx_q + IDX_ONE;
      end
   end

   assign sel_idx = idx_q & mask_q;

   AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) || (mask_q == MASK_OPEN)); // R2
   AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && strobe_set) |=> (idx_q == '0)); // R10
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !wr_hit) |=> (idx_q == IDX_W'($past(idx_q) + IDX_ONE))); // R5
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && !wr_hit) |=> $stable(idx_q)); // R8
endmodule

// File: rtl/btn_read_fmt.sv
module btn_read_fmt #(
   parameter int unsigned NUM_BTN = 8,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_hit,
   input  logic [NUM_BTN-1:0] held,
   input  logic [IDX_W-1:0]   sel_idx,
   output logic [DATA_W-1:0]  rd_data
);
   import btn_port_pkg::*;

   logic              bit_sel;
   logic [DATA_W-1:0] word;

   generate
      if (DATA_W != 8) begin : g_bad_d
         $error("btn_read_fmt: DATA_W must be 8");
      end
   endgenerate

   assign bit_sel = held[sel_idx];
   assign word    = rd_hit ? fmt_byte(bit_sel) : '0;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else begin
               rd_data <= word;
            end
         end
      end else begin : g_comb
         assign rd_data = word;
         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_hit |-> (rd_data == '0)); // R6
      end
   endgenerate

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:1] == '0); // R6
endmodule

// File: rtl/btn_serial_port.sv
module btn_serial_port #(
   parameter int unsigned NUM_BTN = 8,
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_hit,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_BTN-1:0] buttons
);
   import btn_port_pkg::*;

   localparam int unsigned IDX_W = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1;

   generate
      if ((1 << IDX_W) != NUM_BTN) begin : g_bad_pow2
         $error("btn_serial_port: NUM_BTN must be a power of two above 1");
      end
   endgenerate

   logic               rd_hit;
   logic               wr_hit;
   logic               strobe_set;
   logic               strobe_q;
   logic [NUM_BTN-1:0] held;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   mask_q;
   logic [IDX_W-1:0]   sel_idx;

   assign rd_hit     = port_hit & rd_stb;
   assign wr_hit     = port_hit & wr_stb;
   assign strobe_set = wr_data[STROBE_BIT];

   btn_latch #(.NUM_BTN(NUM_BTN)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .strobe_set(strobe_set),
      .btn_in    (buttons),
      .strobe_q  (strobe_q),
      .held_q    (held)
   );

   btn_index #(.IDX_W(IDX_W)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (rd_hit),
      .wr_hit    (wr_hit),
      .strobe_set(strobe_set),
      .idx_q     (idx_q),
      .mask_q    (mask_q),
      .sel_idx   (sel_idx)
   );

   btn_read_fmt #(
      .NUM_BTN(NUM_BTN),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .OUT_REG(OUT_REG)
   ) u_fmt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hit (rd_hit),
      .held   (held),
      .sel_idx(sel_idx),
      .rd_data(rd_data)
   );

   // Strobe flag and mask live in separate submodules and must agree
   AST_STROBE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> (mask_q == '0)); // R2
   AST_FREE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_q |-> (mask_q == {IDX_W{1'b1}})); // R3
endmodule

// File: tb/btn_serial_port_bench.sv
module btn_serial_port_bench;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_hit = 1'b0;
   logic       rd_stb = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] buttons = 8'h00;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   // Reference state kept from the requirements
   logic [2:0] m_idx = 3'd0;
   logic [2:0] m_mask = 3'd7;
   logic [7:0] m_held = 8'h00;
   logic       m_strobe = 1'b0;

   btn_serial_port u_btn_serial_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_hit(port_hit),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .buttons (buttons)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Driver: one bus cycle, expected read pushed, model advanced to next edge
   task automatic bus(input logic hit, input logic rd, input logic wr,
                      input logic [7:0] d, input logic [7:0] btn, input string tag);
      @(negedge clk);
      port_hit = hit;
      rd_stb   = rd;
      wr_stb   = wr;
      wr_data  = d;
      buttons  = btn;
      if (hit && rd) begin
         exp_q.push_back({7'b0, m_held[m_idx & m_mask]});
         tag_q.push_back(tag);
      end
      if (m_strobe) m_held = btn;
      if (hit && wr) begin
         m_strobe = d[0];
         m_mask   = d[0] ? 3'd0 : 3'd7;
         if (d[0]) m_idx = 3'd0;
         else if (rd) m_idx = m_idx + 3'd1;
      end else if (hit && rd) begin
         m_idx = m_idx + 3'd1;
      end
   endtask

   // Monitor: pops expected reads, checks idle cycles read zero
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (port_hit && rd_stb) begin
               if (exp_q.size() == 0) begin
                  check(rd_data, 8'hxx, "scoreboard underflow");
               end else begin
                  check(rd_data, exp_q.pop_front(), tag_q.pop_front());
               end
            end else begin
               check(rd_data, 8'h00, "R6/R8 idle read data");
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, read with all buttons pressed yields 0
      bus(1, 0, 0, 8'h00, 8'hFF, "R1 idle after reset");
      bus(1, 1, 0, 8'h00, 8'hFF, "R1 read after reset");
      // R2: strobe set, reads return button 0 following live input
      bus(1, 0, 1, 8'h01, 8'hA5, "R2 strobe set");
      bus(1, 1, 0, 8'h00, 8'hA5, "R2 strobed read a");
      bus(1, 1, 0, 8'h00, 8'hA4, "R2 strobed read b");
      bus(1, 1, 0, 8'h00, 8'hA4, "R2 strobed read tracks input");
      // R3/R4/R5: release without strobed reads, then walk and wrap
      bus(1, 0, 1, 8'h01, 8'h00, "R2 strobe again");
      bus(1, 0, 1, 8'h00, 8'h96, "R3 release capture");
      for (int i = 0; i < 8; i++) begin
         bus(1, 1, 0, 8'h00, 8'h3C ^ 8'(i), "R4 walk, R3 frozen");
      end
      bus(1, 1, 0, 8'h00, 8'hFF, "R5 wrap to button 0");
      bus(1, 1, 0, 8'h00, 8'hFF, "R5 after wrap");
      // R8: accesses without hit ignored
      bus(0, 1, 0, 8'h00, 8'h00, "R8 read no hit");
      bus(0, 0, 1, 8'h01, 8'h00, "R8 write no hit");
      bus(1, 1, 0, 8'h00, 8'h00, "R8 index not stepped");
      // R7: only bit 0 of write data is used
      bus(1, 0, 1, 8'hFF, 8'h55, "R7 write FF sets strobe");
      bus(1, 1, 0, 8'h00, 8'h55, "R7 strobed read");
      bus(1, 0, 1, 8'hFE, 8'h6B, "R7 write FE releases");
      for (int i = 0; i < 3; i++) begin
         bus(1, 1, 0, 8'h00, 8'h00, "R7 walk after FE");
      end
      // R9: strobed reads advance index through release
      bus(1, 0, 1, 8'h01, 8'hC8, "R9 strobe set");
      for (int i = 0; i < 3; i++) begin
         bus(1, 1, 0, 8'h00, 8'hC8, "R9 strobed read");
      end
      bus(1, 0, 1, 8'h00, 8'hC8, "R9 release");
      bus(1, 1, 0, 8'h00, 8'h00, "R9 first read is button 3");
      bus(1, 1, 0, 8'h00, 8'h00, "R9 second read is button 4");
      // R10: read and write in the same cycle
      bus(1, 1, 1, 8'h01, 8'h00, "R10 read with strobe write");
      bus(1, 0, 1, 8'h00, 8'hE1, "R10 release");
      bus(1, 1, 0, 8'h00, 8'h00, "R10 index cleared");
      bus(1, 1, 1, 8'h00, 8'h00, "R10 read with release write");
      bus(1, 1, 0, 8'h00, 8'h00, "R10 index stepped");
      bus(1, 0, 0, 8'h00, 8'h00, "R6 final idle");
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard: %0d reads unchecked, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule